// File: doc/BRIEF.md
# Adaptive Cost-Aware Replacement Selector

This block decides at run time whether a cache should evict by pure recency or by a linear score that adds a weighted miss cost to recency. A fixed group of leader sets drives the decision. For every access to a leader set, the surrounding cache reports two things: whether the main tag array hit (leader sets there always run the cost-aware policy) and whether a shadow tag directory running plain recency hit. It also reports the 3-bit quantized cost of the miss. A global saturating counter moves by that cost whenever the two structures disagree. Its top bit chooses the policy for every set that is not a leader.

The block also contains the victim chooser. For one set, the caller supplies a recency rank and a 3-bit cost for each way, plus a 2-bit cost weight. The chooser returns the way to evict under the policy that applies to that set. Rank 0 means least recently used. The victim is the way with the smallest score, and the lowest way index wins a tie. The tag arrays themselves are outside the block.

Top module: `adaptive_repl_sel`

## Requirements
- R1: After reset the selection counter `sel_cnt_o` holds the midpoint 512 (bit 9 set), so `policy_cost_o` is 1.
- R2: A set index is a leader when index bits [4:0] equal bits [9:5]. Only an update with `upd_valid_i`=1 to a leader set may change the counter.
- R3: When `main_hit_i` equals `aux_hit_i` (both hit or both miss), the counter does not change.
- R4: When `main_hit_i`=1 and `aux_hit_i`=0, the counter rises by `miss_cost_i` and saturates at 1023.
- R5: When `main_hit_i`=0 and `aux_hit_i`=1, the counter falls by `miss_cost_i` and saturates at 0.
- R6: A counter change is visible on `sel_cnt_o` and `policy_cost_o` one clock edge after the update is presented. `policy_cost_o` is bit 9 of the counter.
- R7: For a query set that is not a leader, `use_cost_o` equals `policy_cost_o`.
- R8: For a query set that is a leader, `use_cost_o` is always 1.
- R9: When `use_cost_o`=0, `victim_o` is the way with the minimum rank. On a tie the lowest way index wins.
- R10: When `use_cost_o`=1, `victim_o` is the way that minimizes rank + `cost_wt_i`*cost. On a tie the lowest way index wins. When `cost_wt_i`=0 the result is the same as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_valid_i | input | 1 | An access outcome is reported this cycle |
| upd_set_i | input | 10 | Set index of the reported access |
| main_hit_i | input | 1 | Hit in the main tag array |
| aux_hit_i | input | 1 | Hit in the recency-only shadow directory |
| miss_cost_i | input | 3 | Quantized cost of the miss |
| qry_set_i | input | 10 | Set index of the victim query |
| qry_rank_i | input | 64 | Recency rank per way, way i at [4i+3:4i], 0 = least recent |
| qry_cost_i | input | 48 | Cost per way, way i at [3i+2:3i] |
| cost_wt_i | input | 2 | Weight of the cost term |
| victim_o | output | 4 | Way chosen for eviction |
| use_cost_o | output | 1 | The query was answered with the cost-aware score |
| policy_cost_o | output | 1 | Policy for follower sets, 1 = cost-aware |
| sel_cnt_o | output | 10 | Selection counter value |

## Verification
Every cycle, the assertions check the following:
- the counter's direction of movement for each outcome pair;
- that the counter is stable when there is no valid leader update;
- the policy routing for leader and follower queries;
- that the victim's score is no larger than the scores of the first and last way.

The bench's reference model is needed for the rest:
- exact update amounts;
- both saturation limits;
- the lowest-index tie rule;
- agreement of the victim with a full minimum search over random ranks, costs and weights.

// File: rtl/repl_sel_pkg.sv
package repl_sel_pkg;
  localparam int unsigned DEF_SET_W  = 10;
  localparam int unsigned DEF_LDR_W  = 5;
  localparam int unsigned DEF_CNT_W  = 10;
  localparam int unsigned DEF_WAYS   = 16;
  localparam int unsigned DEF_COST_W = 3;
  localparam int unsigned DEF_WT_W   = 2;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/leader_detect.sv
module leader_detect #(
  parameter int unsigned SET_W = 10,
  parameter int unsigned LDR_W = 5
) (
  input  logic [SET_W-1:0] set_i,
  output logic             leader_o
);
  logic [SET_W-1:0] unused_hi;
  // leader when the two low index fields match
  assign leader_o  = (set_i[LDR_W-1:0] == set_i[2*LDR_W-1:LDR_W]);
  assign unused_hi = set_i;
endmodule

// File: rtl/policy_counter.sv
module policy_counter
  import repl_sel_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned COST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  upd_kind_e         kind_i,
  input  logic [COST_W-1:0] amt_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W-1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, amt_ext;
  logic [CNT_W:0]   sum;

  assign amt_ext = CNT_W'(amt_i);
  assign sum     = {1'b0, cnt_q} + {1'b0, amt_ext};

  always_comb begin
    cnt_d = cnt_q;
    unique case (kind_i)
      UPD_INC: cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
      UPD_DEC: cnt_d = (cnt_q < amt_ext) ? '0 : cnt_q - amt_ext;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_MID;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/victim_chooser.sv
module victim_chooser #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned COST_W = 3,
  parameter int unsigned WT_W   = 2,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned RANK_W = $clog2(WAYS)
) (
  input  logic [WAYS*RANK_W-1:0] rank_i,
  input  logic [WAYS*COST_W-1:0] cost_i,
  input  logic [WT_W-1:0]        wt_i,
  input  logic                   use_cost_i,
  output logic [WAY_W-1:0]       victim_o
);
  localparam int unsigned SCORE_W = RANK_W + COST_W + WT_W + 1;

  logic [WT_W-1:0]    eff_wt;
  logic [SCORE_W-1:0] score [WAYS];

  assign eff_wt = use_cost_i ? wt_i : '0;

  for (genvar w = 0; w < WAYS; w++) begin : g_score
    assign score[w] = SCORE_W'(rank_i[w*RANK_W +: RANK_W])
                    + SCORE_W'(eff_wt) * SCORE_W'(cost_i[w*COST_W +: COST_W]);
  end

  // linear scan, strict less-than keeps lowest index on ties
  always_comb begin
    logic [SCORE_W-1:0] best;
    best     = score[0];
    victim_o = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (score[w] < best) begin
        best     = score[w];
        victim_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/adaptive_repl_sel.sv
module adaptive_repl_sel
  import repl_sel_pkg::*;
#(
  parameter int unsigned SET_W  = DEF_SET_W,
  parameter int unsigned LDR_W  = DEF_LDR_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned COST_W = DEF_COST_W,
  parameter int unsigned WT_W   = DEF_WT_W,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned RANK_W = $clog2(WAYS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   upd_valid_i,
  input  logic [SET_W-1:0]       upd_set_i,
  input  logic                   main_hit_i,
  input  logic                   aux_hit_i,
  input  logic [COST_W-1:0]      miss_cost_i,
  input  logic [SET_W-1:0]       qry_set_i,
  input  logic [WAYS*RANK_W-1:0] qry_rank_i,
  input  logic [WAYS*COST_W-1:0] qry_cost_i,
  input  logic [WT_W-1:0]        cost_wt_i,
  output logic [WAY_W-1:0]       victim_o,
  output logic                   use_cost_o,
  output logic                   policy_cost_o,
  output logic [CNT_W-1:0]       sel_cnt_o
);
  logic      upd_leader, qry_leader;
  upd_kind_e kind;

  leader_detect #(.SET_W(SET_W), .LDR_W(LDR_W)) u_upd_ldr (
    .set_i(upd_set_i), .leader_o(upd_leader)
  );
  leader_detect #(.SET_W(SET_W), .LDR_W(LDR_W)) u_qry_ldr (
    .set_i(qry_set_i), .leader_o(qry_leader)
  );

  always_comb begin
    kind = UPD_HOLD;
    if (upd_valid_i && upd_leader) begin
      if (main_hit_i && !aux_hit_i)      kind = UPD_INC;
      else if (!main_hit_i && aux_hit_i) kind = UPD_DEC;
    end
  end

  policy_counter #(.CNT_W(CNT_W), .COST_W(COST_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kind_i(kind),
    .amt_i (miss_cost_i),
    .cnt_o (sel_cnt_o)
  );

  assign policy_cost_o = sel_cnt_o[CNT_W-1];
  assign use_cost_o    = qry_leader | policy_cost_o;

  victim_chooser #(.WAYS(WAYS), .COST_W(COST_W), .WT_W(WT_W)) u_vic (
    .rank_i    (qry_rank_i),
    .cost_i    (qry_cost_i),
    .wt_i      (cost_wt_i),
    .use_cost_i(use_cost_o),
    .victim_o  (victim_o)
  );
endmodule

// File: rtl/adaptive_repl_sel_chk.sv
module adaptive_repl_sel_chk #(
  parameter int unsigned SET_W  = 10,
  parameter int unsigned LDR_W  = 5,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned WAYS   = 16,
  parameter int unsigned COST_W = 3,
  parameter int unsigned WT_W   = 2,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned RANK_W = $clog2(WAYS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   upd_valid_i,
  input logic [SET_W-1:0]       upd_set_i,
  input logic                   main_hit_i,
  input logic                   aux_hit_i,
  input logic [COST_W-1:0]      miss_cost_i,
  input logic [SET_W-1:0]       qry_set_i,
  input logic [WAYS*RANK_W-1:0] qry_rank_i,
  input logic [WAYS*COST_W-1:0] qry_cost_i,
  input logic [WT_W-1:0]        cost_wt_i,
  input logic [WAY_W-1:0]       victim_o,
  input logic                   use_cost_o,
  input logic                   policy_cost_o,
  input logic [CNT_W-1:0]       sel_cnt_o
);
  localparam int unsigned SC_W = RANK_W + COST_W + WT_W + 1;

  logic upd_ldr, qry_ldr, moves;
  logic [SC_W-1:0] sc_vic, sc_first, sc_last;
  logic [WT_W-1:0] wt;

  assign upd_ldr = upd_set_i[LDR_W-1:0] == upd_set_i[2*LDR_W-1:LDR_W];
  assign qry_ldr = qry_set_i[LDR_W-1:0] == qry_set_i[2*LDR_W-1:LDR_W];
  assign moves   = upd_valid_i && upd_ldr && (main_hit_i != aux_hit_i);
  assign wt      = use_cost_o ? cost_wt_i : '0;

  assign sc_vic   = SC_W'(qry_rank_i[victim_o*RANK_W +: RANK_W])
                  + SC_W'(wt) * SC_W'(qry_cost_i[victim_o*COST_W +: COST_W]);
  assign sc_first = SC_W'(qry_rank_i[0 +: RANK_W])
                  + SC_W'(wt) * SC_W'(qry_cost_i[0 +: COST_W]);
  assign sc_last  = SC_W'(qry_rank_i[(WAYS-1)*RANK_W +: RANK_W])
                  + SC_W'(wt) * SC_W'(qry_cost_i[(WAYS-1)*COST_W +: COST_W]);

  // R2 R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !moves |=> $stable(sel_cnt_o));

  // R4
  cnt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (moves && main_hit_i) |=> (sel_cnt_o >= $past(sel_cnt_o)));

  // R5
  cnt_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (moves && aux_hit_i) |=> (sel_cnt_o <= $past(sel_cnt_o)));

  // R7
  follower_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qry_ldr |-> (use_cost_o == policy_cost_o));

  // R8
  leader_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_ldr |-> use_cost_o);

  // R9 R10
  victim_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_vic <= sc_first) && (sc_vic <= sc_last));
endmodule

bind adaptive_repl_sel adaptive_repl_sel_chk #(
  .SET_W(SET_W), .LDR_W(LDR_W), .CNT_W(CNT_W),
  .WAYS(WAYS), .COST_W(COST_W), .WT_W(WT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_valid_i(upd_valid_i),
  .upd_set_i(upd_set_i), .main_hit_i(main_hit_i), .aux_hit_i(aux_hit_i),
  .miss_cost_i(miss_cost_i), .qry_set_i(qry_set_i), .qry_rank_i(qry_rank_i),
  .qry_cost_i(qry_cost_i), .cost_wt_i(cost_wt_i), .victim_o(victim_o),
  .use_cost_o(use_cost_o), .policy_cost_o(policy_cost_o), .sel_cnt_o(sel_cnt_o)
);

// File: tb/adaptive_repl_sel_bench.sv
`timescale 1ns/1ps
module adaptive_repl_sel_bench;
  localparam int WAYS = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_valid_i = 1'b0;
  logic [9:0]  upd_set_i = '0;
  logic        main_hit_i = 1'b0;
  logic        aux_hit_i = 1'b0;
  logic [2:0]  miss_cost_i = '0;
  logic [9:0]  qry_set_i = 10'h001;
  logic [63:0] qry_rank_i = '0;
  logic [47:0] qry_cost_i = '0;
  logic [1:0]  cost_wt_i = '0;
  logic [3:0]  victim_o;
  logic        use_cost_o, policy_cost_o;
  logic [9:0]  sel_cnt_o;

  int n_chk = 0, n_fail = 0, exp_cnt = 512;
  bit done = 0;
  int rk [WAYS];
  int cs [WAYS];

  adaptive_repl_sel u_adaptive_repl_sel (.*);

  always #2 clk_i = ~clk_i;

  function automatic bit is_leader(logic [9:0] s);
    return s[4:0] == s[9:5];
  endfunction

  function automatic int ref_victim(bit uc, int wt);
    int best = 1 << 30, idx = 0;
    for (int w = 0; w < WAYS; w++) begin
      int sc = rk[w] + (uc ? wt * cs[w] : 0);
      if (sc < best) begin best = sc; idx = w; end
    end
    return idx;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pack_query();
    for (int w = 0; w < WAYS; w++) begin
      qry_rank_i[w*4 +: 4] = 4'(rk[w]);
      qry_cost_i[w*3 +: 3] = 3'(cs[w]);
    end
  endtask

  // one cycle: drive at negedge, check query, clock, check counter
  task automatic cycle(bit v, logic [9:0] s, bit mh, bit ah, int c);
    bit uc;
    @(negedge clk_i);
    upd_valid_i = v; upd_set_i = s; main_hit_i = mh; aux_hit_i = ah;
    miss_cost_i = 3'(c);
    pack_query();
    #1;
    uc = is_leader(qry_set_i) || (exp_cnt >= 512);
    if (is_leader(qry_set_i)) check("R8 leader use_cost", int'(use_cost_o), 1);
    else                      check("R7 follower use_cost", int'(use_cost_o), int'(uc));
    if (uc) check("R10 cost victim", int'(victim_o), ref_victim(1, int'(cost_wt_i)));
    else    check("R9 lru victim", int'(victim_o), ref_victim(0, 0));
    if (v && is_leader(s) && mh && !ah) exp_cnt = (exp_cnt + c > 1023) ? 1023 : exp_cnt + c;
    if (v && is_leader(s) && !mh && ah) exp_cnt = (exp_cnt < c) ? 0 : exp_cnt - c;
    @(posedge clk_i); #1;
    check("R6 counter", int'(sel_cnt_o), exp_cnt);
    check("R6 policy bit", int'(policy_cost_o), exp_cnt >= 512 ? 1 : 0);
  endtask

  task automatic rand_query();
    for (int w = 0; w < WAYS; w++) begin
      rk[w] = ($urandom % 4 == 0) ? 3 : int'($urandom % 16);
      cs[w] = int'($urandom % 8);
    end
    cost_wt_i = 2'($urandom % 4);
    qry_set_i = ($urandom % 3 == 0) ? {2{5'($urandom)}} : 10'($urandom);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int w = 0; w < WAYS; w++) begin rk[w] = WAYS - 1 - w; cs[w] = 0; end
    #9 rst_ni = 1'b1;
    #3;
    check("R1 reset counter", int'(sel_cnt_o), 512);
    check("R1 reset policy", int'(policy_cost_o), 1);

    // R2 non-leader update ignored (bits[4:0]=1, bits[9:5]=0)
    cycle(1, 10'h001, 1, 0, 7);
    cycle(1, 10'h3e0, 0, 1, 7);
    // R2 valid low ignored on leader set
    cycle(0, 10'h000, 1, 0, 7);
    // R3 agree cases
    cycle(1, 10'h000, 1, 1, 5);
    cycle(1, 10'h021, 0, 0, 5);
    // R5 cross below midpoint, follower switches to LRU
    cycle(1, 10'h000, 0, 1, 1);
    check("R5 down by one", int'(sel_cnt_o), 511);
    // R4 back up
    cycle(1, 10'h3ff, 1, 0, 3);
    check("R4 up by cost", int'(sel_cnt_o), 514);

    // R9 ties: all ranks equal -> way 0
    for (int w = 0; w < WAYS; w++) begin rk[w] = 5; cs[w] = 7 - (w % 8); end
    cost_wt_i = 2'd0; qry_set_i = 10'h001;
    cycle(0, 10'h000, 0, 0, 0);
    check("R9 tie lowest index", int'(victim_o), 0);
    // R10 cost weight steers away from costly way 0
    cost_wt_i = 2'd3;
    cycle(0, 10'h000, 0, 0, 0);
    check("R10 weighted pick", int'(victim_o), 7);

    // R4 saturation high
    for (int i = 0; i < 160; i++) cycle(1, 10'h000, 1, 0, 7);
    check("R4 saturate 1023", int'(sel_cnt_o), 1023);
    // R5 saturation low
    for (int i = 0; i < 160; i++) cycle(1, 10'h042, 0, 1, 7);
    check("R5 saturate 0", int'(sel_cnt_o), 0);
    check("R6 policy lru at 0", int'(policy_cost_o), 0);
    // R8 leader query still cost-aware while follower uses LRU
    qry_set_i = 10'h063;
    cycle(0, 10'h000, 0, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] s;
      rand_query();
      s = ($urandom % 2) ? {2{5'($urandom)}} : 10'($urandom);
      cycle(bit'($urandom % 4 != 0), s, bit'($urandom), bit'($urandom),
            int'($urandom % 8));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule